// File: doc/BRIEF.md
# Atomic-Write Interrupt Controller

This block gathers up to fifteen interrupt source lines into one 32-bit memory-mapped control word and drives a single interrupt request toward a processor. Each source has a sticky pending flag and a mask bit. The request is raised only when the global enable is on and at least one line is both pending and unmasked.

Writes do not simply overwrite the word. Each field has its own write rule, so that software can do three things in one bus write without a read-modify-write sequence: add lines to the mask, remove lines from the mask, and acknowledge lines. The global enable bit of the written word does two jobs. It loads the global enable, and it selects whether the mask bits written as 1 are added or removed. Pending flags are cleared by writing 1 to them. A bus decoder outside this block supplies a write strobe for this register. Reads return the current word at any time.

Top module: `atomic_irq_ctrl`

## Requirements
- R1: The word has this layout: bit 31 is the global enable, bits 30:16 are the mask (bit 16+i for source i), bit 15 is the summary flag, and bits 14:0 are the pending flags (bit i for source i).
- R2: Every write loads bit 31 of the written word into the global enable, starting the cycle after the write.
- R3: A write with bit 31 = 1 sets each mask bit written as 1. Mask bits written as 0 keep their value.
- R4: A write with bit 31 = 0 clears each mask bit written as 1. Mask bits written as 0 keep their value.
- R5: A source line that is high at a clock edge sets its pending flag from the next cycle. The flag stays set while no acknowledge for it is written.
- R6: Writing 1 to a pending-flag position clears that flag on the next cycle. Writing 0 there leaves the flag unchanged.
- R7: If a source line is high in the same cycle as the write that acknowledges it, the pending flag stays set.
- R8: Bit 15 reads 1 exactly when some line is both masked-in and pending. Bit 15 is read-only, so the value written to it has no effect.
- R9: The interrupt output is high exactly when the summary flag and the global enable are both 1.
- R10: Reset clears the global enable, every mask bit and every pending flag, so the word reads 0 and the interrupt output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | 32 | Written word |
| src | input | 15 | Interrupt source lines, active high |
| rd_word | output | 32 | Current control word |
| irq_out | output | 1 | Interrupt request to the processor |

## Verification
The assertions check the following on every cycle: the global enable loads from each write, the mask is updated in set mode and in clear mode, pending flags stick while a source is high, the summary bit agrees with the mask and pending fields, and the output is gated. Some behaviours can only be shown by the bench's sequences of writes, using values it predicts for each cycle. These are the reset value, acknowledges that leave unacknowledged flags alone, the race between a source and its own acknowledge, and a write to the read-only summary bit.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  // default number of source lines; the word is two bits per line plus two
  localparam int DEF_SRC = 15;

  // meaning of the global-enable bit when applied to the mask field
  typedef enum logic {
    MASK_DROP = 1'b0,
    MASK_ADD  = 1'b1
  } mask_mode_e;
endpackage

// File: rtl/irqc_mask_reg.sv
module irqc_mask_reg #(
  parameter int NUM_SRC = irqc_pkg::DEF_SRC
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic               wr_gie,
  input  logic [NUM_SRC-1:0] wr_mask,
  output logic               gie,
  output logic [NUM_SRC-1:0] mask
);
  import irqc_pkg::*;

  mask_mode_e mode;
  assign mode = mask_mode_e'(wr_gie);

  always_ff @(posedge clk) begin
    if (rst) begin
      gie  <= 1'b0;
      mask <= '0;
    end else if (wr_en) begin
      gie <= wr_gie;
      if (mode == MASK_ADD) mask <= mask | wr_mask;
      else                  mask <= mask & ~wr_mask;
    end
  end
endmodule

// File: rtl/irqc_pend_reg.sv
module irqc_pend_reg #(
  parameter int NUM_SRC = irqc_pkg::DEF_SRC
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               ack_en,
  input  logic [NUM_SRC-1:0] ack_bits,
  input  logic [NUM_SRC-1:0] src,
  output logic [NUM_SRC-1:0] pend
);
  for (genvar i = 0; i < NUM_SRC; i++) begin : g_line
    // a live source wins over an acknowledge in the same cycle
    always_ff @(posedge clk) begin
      if (rst)                       pend[i] <= 1'b0;
      else if (src[i])               pend[i] <= 1'b1;
      else if (ack_en && ack_bits[i]) pend[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/atomic_irq_ctrl.sv
module atomic_irq_ctrl #(
  parameter int NUM_SRC = irqc_pkg::DEF_SRC,
  localparam int WORD_W = 2 * NUM_SRC + 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [WORD_W-1:0]  wr_data,
  input  logic [NUM_SRC-1:0] src,
  output logic [WORD_W-1:0]  rd_word,
  output logic               irq_out
);
  localparam int GIE_BIT  = WORD_W - 1;
  localparam int MASK_LO  = NUM_SRC + 1;
  localparam int ANY_BIT  = NUM_SRC;

  logic               gie;
  logic [NUM_SRC-1:0] mask;
  logic [NUM_SRC-1:0] pend;
  logic               any_hit;

  irqc_mask_reg #(.NUM_SRC(NUM_SRC)) u_mask (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_gie  (wr_data[GIE_BIT]),
    .wr_mask (wr_data[GIE_BIT-1:MASK_LO]),
    .gie     (gie),
    .mask    (mask)
  );

  irqc_pend_reg #(.NUM_SRC(NUM_SRC)) u_pend (
    .clk      (clk),
    .rst      (rst),
    .ack_en   (wr_en),
    .ack_bits (wr_data[NUM_SRC-1:0]),
    .src      (src),
    .pend     (pend)
  );

  assign any_hit = |(mask & pend);
  assign rd_word = {gie, mask, any_hit, pend};
  assign irq_out = gie & any_hit;

  // ANY_BIT names the summary position for readers of the layout
  logic unused_any_pos;
  assign unused_any_pos = rd_word[ANY_BIT];
endmodule

// File: rtl/atomic_irq_ctrl_chk.sv
module atomic_irq_ctrl_chk #(
  parameter int NUM_SRC = irqc_pkg::DEF_SRC,
  localparam int WORD_W = 2 * NUM_SRC + 2
) (
  input logic               clk,
  input logic               rst,
  input logic               wr_en,
  input logic [WORD_W-1:0]  wr_data,
  input logic [NUM_SRC-1:0] src,
  input logic [WORD_W-1:0]  rd_word,
  input logic               irq_out
);
  localparam int GB = WORD_W - 1;
  localparam int ML = NUM_SRC + 1;

  logic [NUM_SRC-1:0] c_mask, c_pend, w_mask;
  assign c_mask = rd_word[GB-1:ML];
  assign c_pend = rd_word[NUM_SRC-1:0];
  assign w_mask = wr_data[GB-1:ML];

  p_gie_load_r2: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> rd_word[GB] == $past(wr_data[GB]));

  p_mask_add_r3: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_data[GB]) |=> c_mask == ($past(c_mask) | $past(w_mask)));

  p_mask_drop_r4: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !wr_data[GB]) |=> c_mask == ($past(c_mask) & ~$past(w_mask)));

  p_mask_hold_r3: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(c_mask) && $stable(rd_word[GB]));

  p_pend_set_r5: assert property (@(posedge clk) disable iff (rst)
    (src != '0) |=> (c_pend & $past(src)) == $past(src));

  p_pend_sticky_r6: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> (c_pend & $past(c_pend)) == $past(c_pend));

  p_summary_r8: assert property (@(posedge clk) disable iff (rst)
    rd_word[NUM_SRC] == ((c_mask & c_pend) != '0));

  p_irq_gate_r9: assert property (@(posedge clk) disable iff (rst)
    irq_out == (rd_word[GB] && rd_word[NUM_SRC]));
endmodule

bind atomic_irq_ctrl atomic_irq_ctrl_chk #(.NUM_SRC(NUM_SRC)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .wr_en   (wr_en),
  .wr_data (wr_data),
  .src     (src),
  .rd_word (rd_word),
  .irq_out (irq_out)
);

// File: tb/atomic_irq_ctrl_test.sv
`timescale 1ns/1ps
module atomic_irq_ctrl_test;
  localparam int N = 15;
  localparam int W = 2 * N + 2;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         wr_en = 1'b0;
  logic [W-1:0] wr_data = '0;
  logic [N-1:0] src = '0;
  logic [W-1:0] rd_word;
  logic         irq_out;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  // expected state
  logic         m_gie;
  logic [N-1:0] m_mask, m_pend;

  always #2.5 clk = ~clk;

  atomic_irq_ctrl uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .src(src), .rd_word(rd_word), .irq_out(irq_out)
  );

  function automatic logic [W-1:0] exp_word();
    return {m_gie, m_mask, |(m_mask & m_pend), m_pend};
  endfunction

  function automatic logic exp_irq();
    return m_gie & (|(m_mask & m_pend));
  endfunction

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic compare_all(input string tag);
    check({"R2 gie ", tag}, W'(rd_word[W-1]), W'(m_gie));
    check({"R3/R4 mask ", tag}, W'(rd_word[W-2:N+1]), W'(m_mask));
    check({"R5/R6/R7 pending ", tag}, W'(rd_word[N-1:0]), W'(m_pend));
    check({"R8 summary ", tag}, W'(rd_word[N]), W'(|(m_mask & m_pend)));
    check({"R9 irq ", tag}, W'(irq_out), W'(exp_irq()));
  endtask

  // apply one cycle of stimulus, update the expectation, compare after the edge
  task automatic step(input logic we, input logic [W-1:0] d, input logic [N-1:0] s);
    @(negedge clk);
    wr_en = we; wr_data = d; src = s;
    @(posedge clk);
    if (we) begin
      m_gie = d[W-1];
      if (d[W-1]) m_mask = m_mask | d[W-2:N+1];
      else        m_mask = m_mask & ~d[W-2:N+1];
      m_pend = (m_pend & ~d[N-1:0]) | s;
    end else begin
      m_pend = m_pend | s;
    end
    #1;
    compare_all("step");
  endtask

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240517));
    m_gie = 1'b0; m_mask = '0; m_pend = '0;
    repeat (3) @(posedge clk);
    #1;
    // R10: the reset state
    check("R10 reset word", rd_word, '0);
    check("R10 reset irq", W'(irq_out), '0);
    @(negedge clk); rst = 1'b0;

    // R1: layout, enable line 0 in add mode and pend line 0
    step(1'b1, 32'h8001_0000, 15'h0001);
    #0 check("R1 layout", rd_word, 32'h8001_8001);
    // R6: writing 0 to pending leaves it; writing 1 clears it
    step(1'b1, 32'h8000_0000, '0);
    step(1'b1, 32'h8000_0001, '0);
    // R7: source high with its own acknowledge keeps flag
    step(1'b1, 32'h8000_0004, 15'h0004);
    step(1'b1, 32'h8004_0004, 15'h0004);
    // R4: drop mask bit 2 with gie clear, irq goes low
    step(1'b1, 32'h0004_0000, '0);
    // R8: writing the summary bit does nothing
    step(1'b1, 32'h8000_8000, '0);
    step(1'b1, 32'h0000_8000, '0);
    // R3: adding all lines, then R4 dropping all
    step(1'b1, 32'hFFFF_0000, 15'h7FFF);
    step(1'b1, 32'h7FFF_0000, '0);
    // R5: sticky without writes
    step(1'b0, '0, 15'h4000);
    step(1'b0, '0, '0);

    // random mix
    for (int k = 0; k < 400; k++) begin
      logic we;
      logic [W-1:0] d;
      logic [N-1:0] s;
      we = ($urandom % 3) != 0;
      d  = $urandom;
      s  = (($urandom % 4) == 0) ? N'($urandom) : '0;
      step(we, d, s);
    end

    // R10: reset in the middle clears everything
    @(negedge clk); rst = 1'b1; wr_en = 1'b0; src = '0;
    @(posedge clk); #1;
    check("R10 mid reset", rd_word, '0);
    check("R10 mid reset irq", W'(irq_out), '0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule